// File: doc/BRIEF.md
# Triggered Latency Pipeline Controller

This block keeps a circular store of per-clock hit vectors and, on a trigger, copies the vector that was stored a programmed number of clocks earlier into a small derandomizing queue. A write pointer stores the incoming hit vector into one row on every clock. A trigger pointer trails it by the programmed latency and selects the row to capture. A checker compares the two pointers on every clock and raises a flag when their separation differs from the programmed value.

Each captured event keeps the pipeline row address it came from, protected by a single-error-correcting Hamming code. The readout sequencer sees the head of the queue together with an occupancy count. It pops entries with a read request. A trigger that finds the queue full is discarded and leaves a sticky full indication behind. The memories are behavioural arrays. The configuration interface and the output serializer sit outside this block.

Top module: `trig_latency_pipe`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), occ_o, evt_valid_o, full_o and lat_err_o are all 0.
- R2: On the first clock after reset is released, the write pointer loads lat_i and the trigger pointer loads 0. From then on both advance by one on every clock and wrap from 255 to 0. Each running clock, hit_i is stored in the row under the write pointer.
- R3: A trigger accepted in a cycle captures the row under the trigger pointer as it was before that cycle's write. This is the hit vector presented L clocks earlier, where L is lat_i and the value 0 stands for 256.
- R4: Each queued event carries the trigger pointer value of its capture cycle, and evt_addr_o shows that value for the head event.
- R5: evt_code_o is a 12-bit Hamming code of the 8-bit address a. Data bits a0..a7 sit at code bits 2,4,5,6,8,9,10,11. Code bit 0 is a0^a1^a3^a4^a6, bit 1 is a0^a2^a3^a5^a6, bit 3 is a1^a2^a3^a7, and bit 7 is a4^a5^a6^a7.
- R6: lat_err_o is a registered flag. In the cycle after a running cycle in which (write pointer − trigger pointer) mod 256 differs from lat_i, it is 1. Otherwise it is 0.
- R7: occ_o rises by one for an accepted trigger, falls by one for a pop (rd_req_i while occ_o is nonzero), and stays unchanged when both happen in one cycle. It never exceeds 32.
- R8: Events leave in capture order. evt_valid_o is 1 exactly when occ_o is nonzero, and evt_data_o, evt_addr_o and evt_code_o show the oldest event.
- R9: A trigger while occ_o is 32 is discarded and sets full_o from the next cycle. full_o then stays 1 until a cycle with a pop and no accepted trigger.
- R10: A trigger in the first clock after reset release is ignored. A read request while occ_o is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 128 | Hit vector for the current clock |
| trig_i | input | 1 | Trigger request |
| lat_i | input | 8 | Programmed latency, 0 meaning 256 |
| rd_req_i | input | 1 | Pop request from the readout sequencer |
| evt_valid_o | output | 1 | Queue holds at least one event |
| evt_data_o | output | 128 | Hit vector of the head event |
| evt_addr_o | output | 8 | Decoded pipeline address of the head event |
| evt_code_o | output | 12 | Stored Hamming codeword of the head address |
| occ_o | output | 6 | Number of queued events |
| full_o | output | 1 | Sticky indication that a trigger was discarded |
| lat_err_o | output | 1 | Pointer separation mismatch |

## Verification
The assertions check on every cycle that the pointers step by exactly one, that the occupancy stays within the queue depth, that the queue is never pushed past capacity, that the full flag rises only after a trigger at capacity, and that nothing is captured or flagged before the pointers start. Only the bench scenarios can show that the captured row is the one written exactly L clocks earlier, including the 256-clock case in which capture and overwrite hit the same row. The same holds for the order of events under back-to-back triggers, the recovery of the latency flag once lat_i returns to its start value, and the codeword contents.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

    // Parity bits needed for single-error correction of dw data bits
    function automatic int ham_par_w(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic int ham_code_w(input int dw);
        return dw + ham_par_w(dw);
    endfunction

endpackage

// File: rtl/tlp_ham_enc.sv
module tlp_ham_enc #(
    parameter int DW = 8,
    localparam int PW = tlp_pkg::ham_par_w(DW),
    localparam int CW = DW + PW
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);
    logic [CW-1:0] code_d;

    always_comb begin
        int j;
        logic par;
        code_d = '0;
        j = 0;
        // data fills every position (1-based) that is not a power of two
        for (int pos = 1; pos <= CW; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                code_d[pos-1] = data_i[j];
                j++;
            end
        end
        for (int i = 0; i < PW; i++) begin
            par = 1'b0;
            for (int pos = 1; pos <= CW; pos++) begin
                if ((pos & (1 << i)) != 0) par = par ^ code_d[pos-1];
            end
            code_d[(1 << i) - 1] = par;
        end
    end

    assign code_o = code_d;
endmodule

// File: rtl/tlp_ham_dec.sv
module tlp_ham_dec #(
    parameter int DW = 8,
    localparam int PW = tlp_pkg::ham_par_w(DW),
    localparam int CW = DW + PW
) (
    input  logic [CW-1:0] code_i,
    output logic [DW-1:0] data_o
);
    logic [CW-1:0] fixed_d;
    logic [DW-1:0] data_d;

    always_comb begin
        int syn;
        int j;
        syn = 0;
        for (int pos = 1; pos <= CW; pos++) begin
            if (code_i[pos-1]) syn = syn ^ pos;
        end
        fixed_d = code_i;
        if (syn != 0 && syn <= CW) fixed_d[syn-1] = ~fixed_d[syn-1];
        data_d = '0;
        j = 0;
        for (int pos = 1; pos <= CW; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_d[j] = fixed_d[pos-1];
                j++;
            end
        end
    end

    assign data_o = data_d;
endmodule

// File: rtl/tlp_pipe_ram.sv
module tlp_pipe_ram #(
    parameter int W     = 128,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    // read returns the content before this cycle's write
    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tlp_derand_fifo.sv
module tlp_derand_fifo #(
    parameter int W     = 140,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o
);
    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = st_q.wp + 1'b1;
        if (pop_i)  st_d.rp = st_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[st_q.wp[AW-1:0]] <= push_data_i;
    end

    assign head_o = mem_q[st_q.rp[AW-1:0]];

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !pop_i |-> (st_q.wp - st_q.rp) < (AW+1)'(DEPTH));
endmodule

// File: rtl/trig_latency_pipe.sv
module trig_latency_pipe #(
    parameter int ROW_W      = 128,
    parameter int PIPE_DEPTH = 256,
    parameter int BUF_DEPTH  = 32,
    localparam int PTR_W     = $clog2(PIPE_DEPTH),
    localparam int OCC_W     = $clog2(BUF_DEPTH + 1),
    localparam int CODE_W    = tlp_pkg::ham_code_w(PTR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  hit_i,
    input  logic              trig_i,
    input  logic [PTR_W-1:0]  lat_i,
    input  logic              rd_req_i,
    output logic              evt_valid_o,
    output logic [ROW_W-1:0]  evt_data_o,
    output logic [PTR_W-1:0]  evt_addr_o,
    output logic [CODE_W-1:0] evt_code_o,
    output logic [OCC_W-1:0]  occ_o,
    output logic              full_o,
    output logic              lat_err_o
);
    localparam int ENT_W = CODE_W + ROW_W;

    typedef struct packed {
        logic             run;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] trg;
        logic [OCC_W-1:0] occ;
        logic             full;
        logic             lat_err;
    } state_t;

    state_t st_q, st_d;

    logic             push, pop, drop;
    logic [PTR_W-1:0] sep;
    logic [ROW_W-1:0] row_rd;
    logic [CODE_W-1:0] addr_code;
    logic [ENT_W-1:0] head;

    always_comb begin
        sep  = st_q.wr - st_q.trg;
        push = st_q.run && trig_i && (st_q.occ != OCC_W'(BUF_DEPTH));
        drop = st_q.run && trig_i && (st_q.occ == OCC_W'(BUF_DEPTH));
        pop  = rd_req_i && (st_q.occ != '0);

        st_d = st_q;
        st_d.run = 1'b1;
        if (!st_q.run) begin
            // start: pointers begin already separated by the latency
            st_d.wr  = lat_i;
            st_d.trg = '0;
        end else begin
            st_d.wr  = st_q.wr + 1'b1;
            st_d.trg = st_q.trg + 1'b1;
        end
        st_d.lat_err = st_q.run && (sep != lat_i);
        st_d.occ = st_q.occ + OCC_W'(push) - OCC_W'(pop);
        if (drop)             st_d.full = 1'b1;
        else if (pop && !push) st_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tlp_pipe_ram #(.W(ROW_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk     (clk),
        .we_i    (st_q.run),
        .waddr_i (st_q.wr),
        .wdata_i (hit_i),
        .raddr_i (st_q.trg),
        .rdata_o (row_rd)
    );

    tlp_ham_enc #(.DW(PTR_W)) u_enc (
        .data_i (st_q.trg),
        .code_o (addr_code)
    );

    tlp_derand_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i ({addr_code, row_rd}),
        .pop_i       (pop),
        .head_o      (head)
    );

    tlp_ham_dec #(.DW(PTR_W)) u_dec (
        .code_i (head[ENT_W-1:ROW_W]),
        .data_o (evt_addr_o)
    );

    assign evt_code_o  = head[ENT_W-1:ROW_W];
    assign evt_data_o  = head[ROW_W-1:0];
    assign evt_valid_o = (st_q.occ != '0);
    assign occ_o       = st_q.occ;
    assign full_o      = st_q.full;
    assign lat_err_o   = st_q.lat_err;

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && $past(st_q.run) |->
            (st_q.wr == PTR_W'($past(st_q.wr) + 1'b1)) &&
            (st_q.trg == PTR_W'($past(st_q.trg) + 1'b1)));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_W'(BUF_DEPTH));

    // R9
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(trig_i) && ($past(st_q.occ) == OCC_W'(BUF_DEPTH)));

    // R6
    lat_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lat_err) |-> $past(st_q.run));

    // R10
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.run) |-> (st_q.occ == '0) && !st_q.lat_err);
endmodule

// File: tb/trig_latency_pipe_tb.sv
module trig_latency_pipe_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] hit_i = '0;
    logic         trig_i = 1'b0;
    logic [7:0]   lat_i = 8'd20;
    logic         rd_req_i = 1'b0;
    logic         evt_valid_o;
    logic [127:0] evt_data_o;
    logic [7:0]   evt_addr_o;
    logic [11:0]  evt_code_o;
    logic [5:0]   occ_o;
    logic         full_o;
    logic         lat_err_o;

    always #4 clk = ~clk;

    trig_latency_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .trig_i(trig_i),
        .lat_i(lat_i), .rd_req_i(rd_req_i), .evt_valid_o(evt_valid_o),
        .evt_data_o(evt_data_o), .evt_addr_o(evt_addr_o),
        .evt_code_o(evt_code_o), .occ_o(occ_o), .full_o(full_o),
        .lat_err_o(lat_err_o)
    );

    typedef struct {
        logic [127:0] d;
        logic [7:0]   a;
    } ev_t;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    logic [127:0] pipe_m [256];
    ev_t          q_m [$];
    bit           run_m, full_m, err_m;
    int           wr_m, trg_m;

    function automatic logic [11:0] ham(input logic [7:0] a);
        logic [11:0] c;
        c = '0;
        c[2] = a[0]; c[4] = a[1]; c[5] = a[2]; c[6] = a[3];
        c[8] = a[4]; c[9] = a[5]; c[10] = a[6]; c[11] = a[7];
        c[0] = a[0] ^ a[1] ^ a[3] ^ a[4] ^ a[6];
        c[1] = a[0] ^ a[2] ^ a[3] ^ a[5] ^ a[6];
        c[3] = a[1] ^ a[2] ^ a[3] ^ a[7];
        c[7] = a[4] ^ a[5] ^ a[6] ^ a[7];
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic compare_all;
        chk(occ_o == 6'(q_m.size()), "R7 occupancy", 128'(occ_o), 128'(q_m.size()));
        chk(evt_valid_o == (q_m.size() != 0), "R8 valid", 128'(evt_valid_o), 128'(q_m.size() != 0));
        chk(full_o == full_m, "R9 full flag", 128'(full_o), 128'(full_m));
        chk(lat_err_o == err_m, "R6 latency error", 128'(lat_err_o), 128'(err_m));
        if (q_m.size() != 0) begin
            chk(evt_data_o === q_m[0].d, "R3 R8 head data", evt_data_o, q_m[0].d);
            chk(evt_addr_o == q_m[0].a, "R2 R4 head address", 128'(evt_addr_o), 128'(q_m[0].a));
            chk(evt_code_o == ham(q_m[0].a), "R5 codeword", 128'(evt_code_o), 128'(ham(q_m[0].a)));
        end
    endtask

    // one clock: compare, drive, advance model
    task automatic step(input bit t, input bit r);
        bit   push, pop, drop;
        ev_t  e;
        logic [127:0] h;
        compare_all();
        h = {$urandom, $urandom, $urandom, $urandom};
        hit_i = h; trig_i = t; rd_req_i = r;
        push = run_m && t && (q_m.size() < 32);
        drop = run_m && t && (q_m.size() == 32);
        pop  = r && (q_m.size() != 0);
        e.d = pipe_m[trg_m];
        e.a = 8'(trg_m);
        if (run_m) pipe_m[wr_m] = h;
        err_m = run_m && (((wr_m - trg_m) & 255) != int'(lat_i));
        if (!run_m) begin
            wr_m = int'(lat_i); trg_m = 0; run_m = 1;
        end else begin
            wr_m = (wr_m + 1) & 255; trg_m = (trg_m + 1) & 255;
        end
        if (pop) void'(q_m.pop_front());
        if (push) q_m.push_back(e);
        if (drop) full_m = 1;
        else if (pop && !push) full_m = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] lat);
        rst_n = 1'b0; trig_i = 0; rd_req_i = 0; lat_i = lat;
        run_m = 0; full_m = 0; err_m = 0; wr_m = 0; trg_m = 0;
        q_m.delete();
        repeat (3) @(negedge clk);
        // R1
        chk(occ_o == 0, "R1 reset occupancy", 128'(occ_o), 128'(0));
        chk(evt_valid_o == 0, "R1 reset valid", 128'(evt_valid_o), 128'(0));
        chk(full_o == 0, "R1 reset full", 128'(full_o), 128'(0));
        chk(lat_err_o == 0, "R1 reset latency error", 128'(lat_err_o), 128'(0));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset(8'd20);
        // R10: trigger in the start cycle is ignored
        step(1, 1);
        repeat (300) step(0, 0);
        // mixed triggers every third clock with random pops
        for (int i = 0; i < 90; i++) step(i % 3 == 0, $urandom_range(0, 1) == 1);
        while (q_m.size() != 0) step(0, 1);
        // R10: pop while empty
        repeat (3) step(0, 1);
        chk(occ_o == 0, "R10 empty pop", 128'(occ_o), 128'(0));
        // R9: fill past 32 without pops
        for (int i = 0; i < 120; i++) step(i % 3 == 0, 0);
        chk(full_o == 1, "R9 full after overflow", 128'(full_o), 128'(1));
        chk(occ_o == 32, "R9 occupancy at capacity", 128'(occ_o), 128'(32));
        // R7: trigger and pop together at capacity, then together below it
        step(1, 1);
        step(1, 1);
        step(1, 1);
        while (q_m.size() != 0) step(0, 1);
        chk(full_o == 0, "R9 full cleared", 128'(full_o), 128'(0));
        // R6: latency changed while running, then restored
        lat_i = 8'd25;
        repeat (10) step(0, 0);
        chk(lat_err_o == 1, "R6 mismatch flagged", 128'(lat_err_o), 128'(1));
        lat_i = 8'd20;
        repeat (3) step(1, 0);
        chk(lat_err_o == 0, "R6 mismatch cleared", 128'(lat_err_o), 128'(0));
        while (q_m.size() != 0) step(0, 1);
        // R3: full 256-clock latency (lat 0), capture and overwrite on one row
        do_reset(8'd0);
        repeat (270) step(0, 0);
        for (int i = 0; i < 30; i++) step(i % 3 == 0, i % 2 == 0);
        while (q_m.size() != 0) step(0, 1);
        // R3: shortest latency
        do_reset(8'd1);
        repeat (260) step(0, 0);
        for (int i = 0; i < 30; i++) step(1, i % 3 != 0);
        while (q_m.size() != 0) step(0, 1);
        step(0, 0);
        summary();
    end
endmodule